// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the target side of a two-wire serial bus. A host reaches a small register map inside the chip through it. The block watches the clock and data lines, which are already synchronised to the system clock. It recognises start, repeated start and stop conditions. It compares the 7-bit address at the head of each transfer with a value supplied on an input port, and it answers only when the two match. The data line is open-drain: the block pulls it low by asserting an output enable.

A write transfer sets an internal 8-bit pointer from its first byte. Every later byte is offered to the register file at the pointer location. A parameter mask marks which of the 256 locations exist. The block acknowledges the pointer byte and each data byte only when the location is present in that mask. Bytes aimed at a missing location are dropped. The pointer still advances after every data byte, so a long burst skips over holes and resumes storing at the next present location.

A read transfer returns bytes from the pointer location, most significant bit first, and advances the pointer after each one. The read continues while the host acknowledges and ends when the host declines a byte. Neither a stop nor a repeated start changes the pointer. A host can therefore set the pointer in a short write and follow it at once with a read.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset the data-line enable is low, no write strobe is issued, and the pointer is 0, so the first read returns the byte at location 0.
- R2: SDA falling while SCL is high starts an address phase from any state, and SDA rising while SCL is high returns the block to idle.
- R3: The first byte after a start is the 7-bit address (MSB first) followed by a direction bit (0 write, 1 read). On a match with `dev_addr_i` the block pulls SDA low during the ninth clock. On a mismatch it drives nothing and stores nothing until the next start.
- R4: In a write, the first byte after the address loads the pointer, and it is acknowledged only if bit `p` of `VALID_MASK` is set for the loaded value `p`.
- R5: Each later write byte raises `wr_en_o` for one clock with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte, and is acknowledged, only if the pointer's mask bit is set. Otherwise there is no strobe and no acknowledge.
- R6: The pointer increments by one after every write data byte, whether or not it was stored, so storing and acknowledging resume at the next set mask bit.
- R7: In a read, the block drives the byte at `rd_addr_o` (the pointer) MSB first, increments the pointer after each byte, and sends the next byte while the host acknowledges.
- R8: A host not-acknowledge after a read byte ends the read, and SDA stays released until the next start.
- R9: The pointer is kept across stop and repeated start, so a read that follows begins at the last pointer value.
- R10: The data-line enable changes only while SCL is low on a legal bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| dev_addr_i | input | 7 | Target address from configuration storage |
| wr_en_o | output | 1 | Register file write strobe, one clock |
| wr_addr_o | output | 8 | Register file write location |
| wr_data_o | output | 8 | Register file write byte |
| rd_addr_o | output | 8 | Register file read location (the pointer) |
| rd_data_i | input | 8 | Register file read byte, combinational |

## Verification
The bus events are derived in the same clock in which the line change is first sampled. Every data-line enable change and every write strobe therefore lands one system clock after the SCL falling edge that ends the relevant bit. The bench runs the bus with a quarter-bit of five system clocks. It reads the acknowledge and data bits in the middle of the SCL high phase, several clocks after any change is due. It checks register file contents only after the stop that closes a transfer, by which time every strobe has been issued. A monitor samples the enable and SCL at every clock edge to check that the enable never moves while SCL is high.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MAP_N  = 2 ** BYTE_W;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_END, ST_ACK, ST_TX, ST_TX_ACK, ST_TX_LOAD
  } st_e;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift
  import i2c_regptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  output logic [BYTE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[BYTE_W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit
  import i2c_regptr_pkg::*;
#(
  parameter logic [MAP_N-1:0] VALID_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              inc_i,
  input  logic [BYTE_W-1:0] load_val_i,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              ptr_valid_o,
  output logic              cand_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end

  assign ptr_valid_o  = VALID_MASK[ptr_o];
  assign cand_valid_o = VALID_MASK[load_val_i];

  // R6: pointer steps by exactly one per data byte
  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> ptr_o == $past(ptr_o) + 1'b1);
  // R9: pointer holds when not told to move
  p_ptr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(ptr_o));
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_regptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-2:0] dev_addr_i,
  input  logic [BYTE_W-1:0] sh_q_i,
  input  logic              rd_msb_i,
  input  logic [BYTE_W-1:0] ptr_i,
  input  logic              ptr_valid_i,
  input  logic              cand_valid_i,
  output logic              sh_shift_o,
  output logic              sh_bit_o,
  output logic              sh_load_o,
  output logic              ptr_load_o,
  output logic              ptr_inc_o,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  st_e              state_q;
  kind_e            kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rw_q;
  logic             busy;

  assign busy = ~start_i & ~stop_i;

  always_comb begin
    sh_shift_o = busy & ((state_q == ST_RX & rise_i) |
                         (state_q == ST_TX & fall_i & cnt_q != FULL));
    sh_bit_o   = (state_q == ST_RX) & sda_i;
    sh_load_o  = busy & fall_i & ((state_q == ST_ACK & kind_q == K_ADDR & rw_q) |
                                  state_q == ST_TX_LOAD);
    ptr_load_o = busy & fall_i & state_q == ST_RX_END & kind_q == K_PTR;
    ptr_inc_o  = busy & fall_i & ((state_q == ST_RX_END & kind_q == K_DATA) |
                                  (state_q == ST_TX & cnt_q == FULL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_ADDR;
      cnt_q     <= '0;
      rw_q      <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_RX;
        kind_q   <= K_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: if (rise_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) state_q <= ST_RX_END;
          end
          ST_RX_END: if (fall_i) begin
            unique case (kind_q)
              K_ADDR: begin
                if (sh_q_i[BYTE_W-1:1] == dev_addr_i) begin
                  rw_q     <= sh_q_i[0];
                  sda_oe_o <= 1'b1;
                  state_q  <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              K_PTR: begin
                sda_oe_o <= cand_valid_i;
                state_q  <= ST_ACK;
              end
              default: begin
                if (ptr_valid_i) begin
                  sda_oe_o  <= 1'b1;
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_i;
                  wr_data_o <= sh_q_i;
                end
                state_q <= ST_ACK;
              end
            endcase
          end
          ST_ACK: if (fall_i) begin
            cnt_q <= '0;
            if (kind_q == K_ADDR && rw_q) begin
              sda_oe_o <= ~rd_msb_i;
              state_q  <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RX;
              kind_q   <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
            end
          end
          ST_TX: begin
            if (rise_i) cnt_q <= cnt_q + 1'b1;
            if (fall_i) begin
              if (cnt_q == FULL) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_TX_ACK;
              end else begin
                sda_oe_o <= ~sh_q_i[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: if (rise_i) state_q <= sda_i ? ST_IDLE : ST_TX_LOAD;
          ST_TX_LOAD: if (fall_i) begin
            cnt_q    <= '0;
            sda_oe_o <= ~rd_msb_i;
            state_q  <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  p_start_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RX && kind_q == K_ADDR && cnt_q == '0));
  p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> state_q == ST_IDLE);
  p_idle_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o);
  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_i));
  p_wr_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_regptr_pkg::*;
#(
  parameter logic [MAP_N-1:0] VALID_MASK = {208'h0, 48'hFFFF_0000_FFDF}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BYTE_W-2:0] dev_addr_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i
);
  logic start, stop, rise, fall;
  logic sh_shift, sh_bit, sh_load;
  logic [BYTE_W-1:0] sh_q, ptr;
  logic ptr_load, ptr_inc, ptr_valid, cand_valid;

  i2c_bus_events u_events (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .start_o(start), .stop_o(stop), .scl_rise_o(rise), .scl_fall_o(fall)
  );

  i2c_byte_shift u_shift (
    .clk_i, .rst_ni,
    .shift_i(sh_shift), .bit_i(sh_bit), .load_i(sh_load),
    .load_val_i(rd_data_i), .q_o(sh_q)
  );

  i2c_ptr_unit #(.VALID_MASK(VALID_MASK)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .inc_i(ptr_inc), .load_val_i(sh_q),
    .ptr_o(ptr), .ptr_valid_o(ptr_valid), .cand_valid_o(cand_valid)
  );

  i2c_target_ctrl u_ctrl (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .dev_addr_i, .sh_q_i(sh_q), .rd_msb_i(rd_data_i[BYTE_W-1]),
    .ptr_i(ptr), .ptr_valid_i(ptr_valid), .cand_valid_i(cand_valid),
    .sh_shift_o(sh_shift), .sh_bit_o(sh_bit), .sh_load_o(sh_load),
    .ptr_load_o(ptr_load), .ptr_inc_o(ptr_inc),
    .sda_oe_o, .wr_en_o, .wr_addr_o, .wr_data_o
  );

  assign rd_addr_o = ptr;

  // R5: a strobe only ever targets a present location
  p_wr_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> VALID_MASK[wr_addr_o]);
endmodule

// File: tb/i2c_regptr_target_tb_top.sv
module i2c_regptr_target_tb_top;
  localparam int Q = 5;
  localparam logic [6:0] DEV = 7'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en, sda_line;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] mem [256];
  int n_chk = 0, n_fail = 0, wr_cnt = 0, oe_viol = 0;
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  i2c_regptr_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_addr_i(DEV),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

  always @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rst_n && sda_oe != oe_prev && scl_prev) oe_viol <= oe_viol + 1;
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; hold(Q); scl_m = 1'b1; hold(2 * Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    b = sda_line; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic nak;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(nak);
    ack = ~nak;
  endtask

  task automatic recv_byte(logic m_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~m_ack);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] d;
    chk("R1", "sda_oe after reset", 32'(sda_oe), 0);
    chk("R1", "wr_en after reset", 32'(wr_en), 0);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk("R3", "read address ack", 32'(a), 1);
    recv_byte(1'b0, d);
    chk("R1", "first byte from pointer 0", 32'(d), 32'hA5);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte({DEV + 7'd1, 1'b0}, a);
    chk("R3", "foreign address ack", 32'(a), 0);
    send_byte(8'h03, a);
    chk("R3", "byte after foreign address ack", 32'(a), 0);
    bus_stop();
    chk("R3", "strobes after foreign address", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_burst();
    logic a; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk("R2", "address ack after start", 32'(a), 1);
    send_byte(8'h02, a);
    chk("R4", "valid pointer ack", 32'(a), 1);
    send_byte(8'h11, a);
    chk("R5", "data ack at 02", 32'(a), 1);
    send_byte(8'h22, a);
    chk("R6", "data ack at 03", 32'(a), 1);
    bus_stop();
    chk("R5", "mem[02]", 32'(mem[8'h02]), 32'h11);
    chk("R6", "mem[03]", 32'(mem[8'h03]), 32'h22);
    chk("R5", "strobe count", 32'(wr_cnt - w0), 2);
  endtask

  task automatic t_hole();
    logic a; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h04, a);
    send_byte(8'h33, a);
    chk("R5", "data ack at 04", 32'(a), 1);
    send_byte(8'h44, a);
    chk("R5", "data nack at hole 05", 32'(a), 0);
    send_byte(8'h55, a);
    chk("R6", "data ack resumes at 06", 32'(a), 1);
    bus_stop();
    chk("R5", "mem[04]", 32'(mem[8'h04]), 32'h33);
    chk("R5", "hole mem[05] untouched", 32'(mem[8'h05]), 32'hA0);
    chk("R6", "mem[06]", 32'(mem[8'h06]), 32'h55);
    chk("R6", "strobe count over hole", 32'(wr_cnt - w0), 2);
  endtask

  task automatic t_bad_ptr();
    logic a; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h10, a);
    chk("R4", "invalid pointer nack", 32'(a), 0);
    send_byte(8'h66, a);
    chk("R5", "data nack at 10", 32'(a), 0);
    bus_stop();
    chk("R5", "mem[10] untouched", 32'(mem[8'h10]), 32'hB5);
    chk("R5", "no strobe at invalid", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_rs_read();
    logic a, b; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk("R2", "address ack after repeated start", 32'(a), 1);
    recv_byte(1'b1, d);
    chk("R7", "read byte at 02", 32'(d), 32'h11);
    recv_byte(1'b1, d);
    chk("R7", "read byte at 03", 32'(d), 32'h22);
    recv_byte(1'b0, d);
    chk("R7", "read byte at 04", 32'(d), 32'h33);
    recv_bit(b);
    chk("R8", "line released after host nack", 32'(b), 1);
    bus_stop();
  endtask

  task automatic t_ptr_keep();
    logic a; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk("R9", "address ack", 32'(a), 1);
    recv_byte(1'b0, d);
    chk("R9", "read continues at 05 after stop", 32'(d), 32'hA0);
    bus_stop();
  endtask

  initial begin
    hold(4);
    rst_n = 1'b1;
    hold(4);
    t_reset();
    t_mismatch();
    t_burst();
    t_hole();
    t_bad_ptr();
    t_rs_read();
    t_ptr_keep();
    hold(4);
    chk("R10", "enable changes while SCL high", 32'(oe_viol), 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule